// File: doc/BRIEF.md
# Runaway Watchdog with Selectable Timeout

This block watches for software that has stopped making progress. Software sets an enable bit and a timeout action, then picks one of eight timeout periods. It starts the watchdog by writing a restart strobe. From then on, software must write the strobe again before the period runs out. If the strobe does not arrive in time, the block raises either a system reset request or a non-maskable interrupt request, as the action bit selects.

Timing comes from the main clock. A free-running prescaler of 2^PRE_W cycles feeds a second counter stage. The eight periods are 2^FIRST_EXP up to 2^(FIRST_EXP+6) in power-of-two steps, and the last code gives 2^(FIRST_EXP+8). The restart strobe clears only the second stage, never the prescaler. For this reason a timeout can arrive up to 2^PRE_W − 1 cycles before the nominal period ends.

The block keeps counting while the system is halted. It freezes completely while the system is stopped. Once the watchdog has started, its configuration cannot change until the next reset.

Top module: `runaway_watchdog`

## Requirements
- R1: After a synchronous reset (rst high at a rising edge), wdt_reset and nmi_req are 0. Neither output rises until the watchdog has been started.
- R2: A write to address 0 (mode register) with bit 7 (restart strobe) at 1 starts the watchdog only if the enable bit (bit 4) is 1, either in that same write or already latched. A strobe written with the enable bit at 0 starts nothing.
- R3: Bits 2:0 written to address 1 select the nominal period N in clock cycles. Code c from 0 to 6 gives N = 2^(FIRST_EXP+c). Code 7 gives N = 2^(FIRST_EXP+8).
- R4: The prescaler counts every non-stopped cycle from reset, and the restart strobe never clears it. The timeout output rises after the D-th rising edge that follows the edge accepting the strobe. With q = (non-stopped edges since reset before that edge) mod 2^PRE_W, and j = (2^PRE_W − 1 − q) mod 2^PRE_W replaced by 2^PRE_W when 0, D = j + N − 2^PRE_W. D therefore lies in [N − 2^PRE_W + 1, N].
- R5: Once the watchdog is running, every mode-register write with bit 7 at 1 clears the period counter and restarts the count. A mode write with bit 7 at 0 does not disturb the count.
- R6: With action bit 3 at 1, a timeout sets wdt_reset. wdt_reset stays at 1 until rst, and nmi_req stays at 0.
- R7: With action bit 3 at 0, a timeout makes nmi_req a one-cycle pulse. The counter wraps and keeps running, so the next pulse rises exactly N edges after the previous one.
- R8: After the watchdog has started, writes to the enable bit, the action bit and the period select are ignored until reset.
- R9: halt has no effect on counting. While stop is high, both the prescaler and the counter hold, which delays the timeout by the number of stopped edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main system clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register select: 0 mode, 1 period select |
| wr_data | input | DATA_W | Write data |
| halt | input | 1 | System in HALT state (counting continues) |
| stop | input | 1 | System in STOP state (counting frozen) |
| wdt_reset | output | 1 | Sticky system reset request |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |

## Verification
The hardest situation to reach is a restart strobe that lands exactly one edge before expiry, at a known prescaler phase. The phase is invisible at the ports. The bench keeps its own count of non-stopped edges since reset, so it can predict the phase and the exact expiry edge. It shifts the phase with a chosen number of idle cycles, which makes every phase appear and covers both ends of the early-timeout window. A fixed-seed random sweep over period codes and actions, including the longest code, completes the coverage.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int MODE_ADDR = 0;
  localparam int SEL_ADDR  = 1;
  localparam int RUN_BIT   = 7;
  localparam int EN_BIT    = 4;
  localparam int ACT_BIT   = 3;
  localparam int SEL_W     = 3;
  localparam int NUM_SEL   = 1 << SEL_W;

  typedef struct packed {
    logic             en;
    logic             act_rst;
    logic [SEL_W-1:0] sel;
  } wdt_cfg_t;

  // Extra doubling steps above the shortest period; the top code skips one step.
  function automatic int sel_step(input int code);
    return (code == NUM_SEL - 1) ? code + 1 : code;
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output wdt_cfg_t          cfg,
  output logic              started,
  output logic              kick
);
  logic mode_hit, sel_hit, en_next;
  logic unused_data;

  assign mode_hit = wr_en && (wr_addr == ADDR_W'(MODE_ADDR));
  assign sel_hit  = wr_en && (wr_addr == ADDR_W'(SEL_ADDR));
  assign en_next  = started ? cfg.en : wr_data[EN_BIT];
  assign kick     = mode_hit && wr_data[RUN_BIT] && en_next;
  assign unused_data = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= '0;
      started <= 1'b0;
    end else begin
      if (!started) begin
        if (mode_hit) begin
          cfg.en      <= wr_data[EN_BIT];
          cfg.act_rst <= wr_data[ACT_BIT];
        end
        if (sel_hit) cfg.sel <= wr_data[SEL_W-1:0];
      end
      if (kick) started <= 1'b1;
    end
  end

  // R8
  cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
    started |=> $stable(cfg));
  // R8
  started_hold_chk: assert property (@(posedge clk) disable iff (rst)
    started |=> started);
  // R2
  no_start_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (!started && mode_hit && !wr_data[EN_BIT]) |=> !started);
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic stop,
  input  logic halt,
  output logic tick
);
  logic [PRE_W-1:0] pre_q;
  logic unused_halt;

  assign unused_halt = halt;

  always_ff @(posedge clk) begin
    if (rst)        pre_q <= '0;
    else if (!stop) pre_q <= pre_q + PRE_W'(1);
  end

  assign tick = !stop && (pre_q == {PRE_W{1'b1}});

  // R9
  pre_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    stop |=> $stable(pre_q));
  // R9
  pre_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (!stop || halt && !stop) |=> (pre_q == $past(pre_q) + PRE_W'(1)));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int PRE_W     = 8,
  parameter int FIRST_EXP = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             started,
  input  logic             kick,
  input  logic [SEL_W-1:0] sel,
  output logic             expire
);
  localparam int BASE_SH = FIRST_EXP - PRE_W;
  localparam int CNT_W   = BASE_SH + NUM_SEL;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] last_tab [NUM_SEL];

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_limit
    localparam int SH = BASE_SH + sel_step(g);
    assign last_tab[g] = {CNT_W{1'b1}} >> (CNT_W - SH);
  end

  assign last   = last_tab[sel];
  assign expire = started && tick && !kick && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst || kick) begin
      cnt_q <= '0;
    end else if (started && tick) begin
      cnt_q <= (cnt_q == last) ? '0 : cnt_q + CNT_W'(1);
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last);
  // R5
  kick_clear_chk: assert property (@(posedge clk) disable iff (rst)
    kick |=> (cnt_q == '0));
  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> (cnt_q == '0));
endmodule

// File: rtl/runaway_watchdog.sv
module runaway_watchdog
  import wdt_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 8,
  parameter int PRE_W     = 8,
  parameter int FIRST_EXP = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              halt,
  input  logic              stop,
  output logic              wdt_reset,
  output logic              nmi_req
);
  wdt_cfg_t cfg;
  logic     started, kick, tick, expire;

  wdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg(cfg), .started(started), .kick(kick)
  );

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .stop(stop), .halt(halt), .tick(tick)
  );

  wdt_counter #(.PRE_W(PRE_W), .FIRST_EXP(FIRST_EXP)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .started(started), .kick(kick),
    .sel(cfg.sel), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wdt_reset <= 1'b0;
      nmi_req   <= 1'b0;
    end else begin
      nmi_req <= expire && !cfg.act_rst;
      if (expire && cfg.act_rst) wdt_reset <= 1'b1;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !started |-> (!nmi_req && !wdt_reset));
  // R6
  reset_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    wdt_reset |=> wdt_reset);
  // R7
  nmi_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_req |=> !nmi_req);
  // R7
  nmi_mode_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_req |-> (!cfg.act_rst && !wdt_reset));
  // R6
  reset_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_reset) |-> cfg.act_rst);
endmodule

// File: tb/sim_runaway_watchdog.sv
module sim_runaway_watchdog;
  localparam int PRE_W     = 2;
  localparam int FIRST_EXP = 4;
  localparam int PS        = 1 << PRE_W;

  logic       clk = 1'b0, rst = 1'b1, wr_en = 1'b0, halt = 1'b0, stop = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       wdt_reset, nmi_req;

  int n_chk = 0, n_bad = 0, act = 0, last_q = 0;

  runaway_watchdog #(.ADDR_W(2), .DATA_W(8), .PRE_W(PRE_W), .FIRST_EXP(FIRST_EXP)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .halt(halt), .stop(stop), .wdt_reset(wdt_reset), .nmi_req(nmi_req)
  );

  always #4 clk = ~clk;

  // Non-stopped edges since reset: the prescaler phase is this value mod PS.
  always @(posedge clk) begin
    if (rst) act <= 0;
    else if (!stop) act <= act + 1;
  end

  function automatic int nominal(int code);
    return (code == 7) ? (1 << (FIRST_EXP + 8)) : (1 << (FIRST_EXP + code));
  endfunction

  function automatic int predict(int q, int code);
    int j = (PS - 1 - (q % PS)) % PS;
    if (j == 0) j = PS;
    return j + nominal(code) - PS;
  endfunction

  task automatic check(bit ok, string req, string what, int got, int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp_v);
    end
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; halt = 1'b0; stop = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Called at a negedge; the write is taken at the next rising edge.
  task automatic write_reg(int a, int d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
    last_q = act;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic quiet(int k, string req);
    bit seen = 1'b0;
    for (int i = 0; i < k; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (nmi_req || wdt_reset) seen = 1'b1;
    end
    check(!seen, req, "output stayed low", int'(seen), 0);
  endtask

  task automatic watch(int limit, output int n, output bit sn, output bit sr);
    n = -1; sn = 1'b0; sr = 1'b0;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (nmi_req || wdt_reset) begin
        n = i; sn = nmi_req; sr = wdt_reset;
        break;
      end
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #1200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int d, e, e2, n, code, asel, idl;
    bit sn, sr, held;
    int unsigned seed_v;
    seed_v = $urandom(32'h1d2c);

    reset_dut();
    check(!nmi_req && !wdt_reset, "R1", "outputs after reset", int'(nmi_req | wdt_reset), 0);
    quiet(100, "R1");

    // R2: strobe without enable does nothing
    write_reg(1, 0);
    write_reg(0, 8'h80);
    quiet(64, "R2");

    // R6: reset action, exact expiry edge
    write_reg(0, 8'h98);
    e = predict(last_q, 0);
    watch(nominal(0) + 8, d, sn, sr);
    check(d == e, "R4", "reset-mode expiry edge", d, e);
    check(sr && !sn, "R6", "reset action raised", int'(sr), 1);
    held = 1'b1;
    for (int i = 0; i < 3 * nominal(0); i++) begin
      @(posedge clk); @(negedge clk);
      if (!wdt_reset || nmi_req) held = 1'b0;
    end
    check(held, "R6", "reset request held", int'(held), 1);
    reset_dut();
    check(!wdt_reset && !nmi_req, "R1", "cleared by reset", int'(wdt_reset), 0);

    // R4: every prescaler phase, both ends of the early window
    for (int ph = 0; ph < PS; ph++) begin
      reset_dut();
      idle(ph);
      write_reg(1, 0);
      write_reg(0, 8'h90);
      e = predict(last_q, 0);
      watch(nominal(0) + 8, d, sn, sr);
      check(d == e, "R4", "phase expiry edge", d, e);
      check(d >= nominal(0) - PS + 1 && d <= nominal(0), "R4", "early bound", d, nominal(0));
    end

    // R7: nmi pulse and wrap
    reset_dut();
    write_reg(1, 1);
    write_reg(0, 8'h90);
    e = predict(last_q, 1);
    watch(nominal(1) + 8, d, sn, sr);
    check(d == e, "R7", "first nmi edge", d, e);
    check(sn && !sr, "R7", "nmi action", int'(sn), 1);
    @(posedge clk); @(negedge clk);
    check(!nmi_req, "R7", "nmi single cycle", int'(nmi_req), 0);
    watch(nominal(1) + 8, d, sn, sr);
    check(d == nominal(1) - 1, "R7", "second nmi after wrap", d, nominal(1) - 1);
    check(!sr, "R7", "no reset in nmi mode", int'(sr), 0);

    // R5: restart one edge before expiry
    reset_dut();
    write_reg(1, 2);
    write_reg(0, 8'h90);
    e = predict(last_q, 2);
    quiet(e - 2, "R5");
    write_reg(0, 8'h90);
    check(!nmi_req && !wdt_reset, "R5", "no expiry at kick", int'(nmi_req), 0);
    e2 = predict(last_q, 2);
    watch(nominal(2) + 8, d, sn, sr);
    check(d == e2, "R5", "expiry after late restart", d, e2);

    // R8 and R5: locked fields, write without strobe does not clear
    reset_dut();
    write_reg(1, 3);
    write_reg(0, 8'h90);
    e = predict(last_q, 3);
    write_reg(1, 0);
    write_reg(0, 8'h18);
    watch(nominal(3) + 8, d, sn, sr);
    check(d == e - 2, "R8", "period and count unchanged", d, e - 2);
    check(sn && !sr, "R8", "action unchanged", int'(sr), 0);

    // R9: halt keeps counting
    reset_dut();
    halt = 1'b1;
    write_reg(1, 2);
    write_reg(0, 8'h90);
    e = predict(last_q, 2);
    watch(nominal(2) + 8, d, sn, sr);
    check(d == e, "R9", "halt expiry edge", d, e);
    halt = 1'b0;

    // R9: stop freezes everything
    reset_dut();
    write_reg(1, 1);
    write_reg(0, 8'h90);
    e = predict(last_q, 1);
    idle(10);
    stop = 1'b1;
    quiet(50, "R9");
    stop = 1'b0;
    watch(nominal(1) + 8, d, sn, sr);
    check(d == e - 10, "R9", "expiry delayed by stop", d, e - 10);

    // R3: random codes and actions
    for (int it = 0; it < 10; it++) begin
      code = (it == 0) ? 7 : int'($urandom % 8);
      asel = int'($urandom % 2);
      idl  = int'($urandom % 6);
      reset_dut();
      idle(idl);
      write_reg(1, code);
      write_reg(0, 8'h90 | (asel << 3));
      e = predict(last_q, code);
      watch(nominal(code) + 8, n, sn, sr);
      check(n == e, "R3", "period by code", n, e);
      if (asel == 1) check(sr && !sn, "R6", "random reset action", int'(sr), 1);
      else           check(sn && !sr, "R7", "random nmi action", int'(sn), 1);
    end

    summary();
    $finish;
  end
endmodule